// File: doc/BRIEF.md
# Speculative Register File with Poison Tracking

This block is a register file in which every entry holds a data word and a one-bit poison flag. The flag lets a compiler hoist instructions above branches: when such a hoisted instruction hits an exception that would normally end the program, the hardware does not trap. It marks the destination as poisoned and carries on. The poison then follows the speculative dataflow. Only when an ordinary, non-speculative instruction consumes a poisoned value is a fault raised. That fault names the register that carried the poison, so recovery code can take over.

Two read ports return data together with the poison flag, with no clock delay. A single completion (write) port accepts one retiring instruction per cycle. For that instruction the port carries:

- the destination index and the result data;
- the speculative bit;
- up to two source indices, each with its own use flag;
- a terminating-exception flag and a resumable-exception flag.

A combinational classifier sorts each completion into one outcome, checking in priority order:

1. `OUT_IDLE`: no completion.
2. A used source is poisoned: `OUT_DEFER` for a speculative instruction, `OUT_FAULT` for a non-speculative one.
3. `OUT_RESUME`: a resumable exception.
4. A terminating exception: `OUT_DEFER` if speculative, `OUT_TRAP` if not.
5. `OUT_CLEAN`: everything else.

The outcome drives the storage update and the one-cycle event pulses at the clock edge.

Top module: `spec_poison_regfile`

## Requirements
- R1: While reset is asserted, every poison flag and every data word is cleared to zero, and `fault_valid`, `resume_req` and `trap_req` are low.
- R2: Each read port returns, in the same cycle, the data and poison flag of the entry its index selects, independently of the other port; a write becomes visible on the read ports after the clock edge that performs it.
- R3: A completion with no exception flag and no used poisoned source (`OUT_CLEAN`) writes its data to the destination and clears that destination's poison flag, whether or not it is speculative, and raises no event.
- R4: A speculative completion with the terminating-exception flag set, no used poisoned source and no resumable flag sets the destination poison flag and leaves its data unchanged, with no fault or trap.
- R5: A speculative completion with a used source whose poison flag is set sets the destination poison flag and leaves its data unchanged, with no event, regardless of its exception flags.
- R6: A non-speculative completion with a used poisoned source raises `fault_valid` for exactly the following cycle, with `fault_src_idx` equal to source A's index if source A is used and poisoned, otherwise source B's index; the destination is left unchanged.
- R7: A completion with the resumable-exception flag set and no used poisoned source raises `resume_req` for the following cycle and leaves the destination unchanged, speculative or not.
- R8: A non-speculative completion with the terminating flag set, no resumable flag and no used poisoned source raises `trap_req` for the following cycle and leaves the destination unchanged.
- R9: A source whose use flag is low has no effect through its poison flag: the completion is classified as if that source were clean.
- R10: When `wr_valid` is low, no entry changes and no event is raised in the following cycle.
- R11: At most one of `fault_valid`, `resume_req` and `trap_req` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_a_idx | input | IDX_W | Read port A entry index |
| rd_a_data | output | DATA_W | Read port A data |
| rd_a_poison | output | 1 | Read port A poison flag |
| rd_b_idx | input | IDX_W | Read port B entry index |
| rd_b_data | output | DATA_W | Read port B data |
| rd_b_poison | output | 1 | Read port B poison flag |
| wr_valid | input | 1 | A completion is presented this cycle |
| wr_dest | input | IDX_W | Destination entry index |
| wr_data | input | DATA_W | Result data |
| wr_spec | input | 1 | Completing instruction is speculative |
| wr_use_a | input | 1 | Source A is consumed |
| wr_src_a | input | IDX_W | Source A entry index |
| wr_use_b | input | 1 | Source B is consumed |
| wr_src_b | input | IDX_W | Source B entry index |
| wr_exc_term | input | 1 | Instruction hit a terminating exception |
| wr_exc_resum | input | 1 | Instruction hit a resumable exception |
| fault_valid | output | 1 | Poisoned operand consumed by a non-speculative instruction (one cycle) |
| fault_src_idx | output | IDX_W | Index of the poisoned source that caused the fault |
| resume_req | output | 1 | Resumable exception to be handled now (one cycle) |
| trap_req | output | 1 | Terminating exception on a non-speculative instruction (one cycle) |

## Verification
The assertions rely on two things about the inputs. Every input is a defined 0 or 1 at each rising edge. Completions arrive on the clock, with no handshake, so an event pulse always belongs to the completion of the previous cycle. The bench meets both conditions by driving every input on the falling edge from a fixed-seed random stream, so values are settled well before the edge. It also builds poison on purpose: speculative terminating exceptions are frequent enough that poisoned sources, double-poisoned operands and unused poisoned sources all appear. Directed cases pin down fault attribution and the exception priority.

// File: rtl/spr_pkg.sv
package spr_pkg;

    // Classification of one completion presented on the write port.
    typedef enum logic [2:0] {
        OUT_IDLE   = 3'd0,
        OUT_CLEAN  = 3'd1,
        OUT_DEFER  = 3'd2,
        OUT_FAULT  = 3'd3,
        OUT_RESUME = 3'd4,
        OUT_TRAP   = 3'd5
    } outcome_e;

endpackage

// File: rtl/spr_storage.sv
module spr_storage #(
    parameter int NUM_REGS = 16,
    parameter int DATA_W   = 32,
    parameter int IDX_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_en,
    input  logic              upd_data_en,
    input  logic              upd_poison,
    input  logic [IDX_W-1:0]  upd_idx,
    input  logic [DATA_W-1:0] upd_data,
    input  logic [IDX_W-1:0]  rd_a_idx,
    output logic [DATA_W-1:0] rd_a_data,
    output logic              rd_a_poison,
    input  logic [IDX_W-1:0]  rd_b_idx,
    output logic [DATA_W-1:0] rd_b_data,
    output logic              rd_b_poison,
    input  logic [IDX_W-1:0]  lk_a_idx,
    output logic              lk_a_poison,
    input  logic [IDX_W-1:0]  lk_b_idx,
    output logic              lk_b_poison
);

    logic [DATA_W-1:0] data_q   [NUM_REGS];
    logic              poison_q [NUM_REGS];

    // One storage slice per entry; each decodes its own write select.
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_entry
        logic hit;
        assign hit = upd_en && (upd_idx == IDX_W'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                data_q[g]   <= '0;
                poison_q[g] <= 1'b0;
            end else if (hit) begin
                if (upd_data_en) begin
                    data_q[g] <= upd_data;
                end
                poison_q[g] <= upd_poison;
            end
        end
    end

    // Combinational read of architectural ports and of source poison lookups.
    always_comb begin
        rd_a_data   = data_q[rd_a_idx];
        rd_a_poison = poison_q[rd_a_idx];
        rd_b_data   = data_q[rd_b_idx];
        rd_b_poison = poison_q[rd_b_idx];
        lk_a_poison = poison_q[lk_a_idx];
        lk_b_poison = poison_q[lk_b_idx];
    end

endmodule

// File: rtl/spr_classify.sv
module spr_classify
    import spr_pkg::*;
(
    input  logic     wr_valid,
    input  logic     wr_spec,
    input  logic     use_a,
    input  logic     use_b,
    input  logic     poison_a,
    input  logic     poison_b,
    input  logic     exc_term,
    input  logic     exc_resum,
    output outcome_e outcome,
    output logic     blame_b
);

    logic bad_a;
    logic bad_b;

    // A source only counts when the instruction actually consumes it.
    assign bad_a   = use_a && poison_a;
    assign bad_b   = use_b && poison_b;
    assign blame_b = !bad_a;

    // Priority: poisoned operand, then resumable, then terminating, then clean.
    always_comb begin
        if (!wr_valid) begin
            outcome = OUT_IDLE;
        end else if (bad_a || bad_b) begin
            outcome = wr_spec ? OUT_DEFER : OUT_FAULT;
        end else if (exc_resum) begin
            outcome = OUT_RESUME;
        end else if (exc_term) begin
            outcome = wr_spec ? OUT_DEFER : OUT_TRAP;
        end else begin
            outcome = OUT_CLEAN;
        end
    end

endmodule

// File: rtl/spr_event_regs.sv
module spr_event_regs
    import spr_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  outcome_e         outcome,
    input  logic             blame_b,
    input  logic [IDX_W-1:0] src_a,
    input  logic [IDX_W-1:0] src_b,
    output logic             fault_valid,
    output logic [IDX_W-1:0] fault_src_idx,
    output logic             resume_req,
    output logic             trap_req
);

    logic             fault_d;
    logic             resume_d;
    logic             trap_d;
    logic [IDX_W-1:0] idx_d;

    always_comb begin
        fault_d  = 1'b0;
        resume_d = 1'b0;
        trap_d   = 1'b0;
        idx_d    = '0;
        unique case (outcome)
            OUT_FAULT: begin
                fault_d = 1'b1;
                idx_d   = blame_b ? src_b : src_a;
            end
            OUT_RESUME: resume_d = 1'b1;
            OUT_TRAP:   trap_d   = 1'b1;
            OUT_IDLE, OUT_CLEAN, OUT_DEFER: ;
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fault_valid   <= 1'b0;
            fault_src_idx <= '0;
            resume_req    <= 1'b0;
            trap_req      <= 1'b0;
        end else begin
            fault_valid   <= fault_d;
            fault_src_idx <= idx_d;
            resume_req    <= resume_d;
            trap_req      <= trap_d;
        end
    end

endmodule

// File: rtl/spec_poison_regfile.sv
module spec_poison_regfile
    import spr_pkg::*;
#(
    parameter int NUM_REGS = 16,
    parameter int DATA_W   = 32,
    parameter int IDX_W    = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_a_idx,
    output logic [DATA_W-1:0] rd_a_data,
    output logic              rd_a_poison,
    input  logic [IDX_W-1:0]  rd_b_idx,
    output logic [DATA_W-1:0] rd_b_data,
    output logic              rd_b_poison,
    input  logic              wr_valid,
    input  logic [IDX_W-1:0]  wr_dest,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_spec,
    input  logic              wr_use_a,
    input  logic [IDX_W-1:0]  wr_src_a,
    input  logic              wr_use_b,
    input  logic [IDX_W-1:0]  wr_src_b,
    input  logic              wr_exc_term,
    input  logic              wr_exc_resum,
    output logic              fault_valid,
    output logic [IDX_W-1:0]  fault_src_idx,
    output logic              resume_req,
    output logic              trap_req
);

    outcome_e outcome;
    logic     blame_b;
    logic     lk_a_poison;
    logic     lk_b_poison;
    logic     upd_en;
    logic     upd_data_en;
    logic     upd_poison;

    spr_storage #(
        .NUM_REGS (NUM_REGS),
        .DATA_W   (DATA_W),
        .IDX_W    (IDX_W)
    ) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .upd_en      (upd_en),
        .upd_data_en (upd_data_en),
        .upd_poison  (upd_poison),
        .upd_idx     (wr_dest),
        .upd_data    (wr_data),
        .rd_a_idx    (rd_a_idx),
        .rd_a_data   (rd_a_data),
        .rd_a_poison (rd_a_poison),
        .rd_b_idx    (rd_b_idx),
        .rd_b_data   (rd_b_data),
        .rd_b_poison (rd_b_poison),
        .lk_a_idx    (wr_src_a),
        .lk_a_poison (lk_a_poison),
        .lk_b_idx    (wr_src_b),
        .lk_b_poison (lk_b_poison)
    );

    spr_classify u_class (
        .wr_valid  (wr_valid),
        .wr_spec   (wr_spec),
        .use_a     (wr_use_a),
        .use_b     (wr_use_b),
        .poison_a  (lk_a_poison),
        .poison_b  (lk_b_poison),
        .exc_term  (wr_exc_term),
        .exc_resum (wr_exc_resum),
        .outcome   (outcome),
        .blame_b   (blame_b)
    );

    // Storage update decoded from the outcome.
    always_comb begin
        upd_en      = 1'b0;
        upd_data_en = 1'b0;
        upd_poison  = 1'b0;
        unique case (outcome)
            OUT_CLEAN: begin
                upd_en      = 1'b1;
                upd_data_en = 1'b1;
            end
            OUT_DEFER: begin
                upd_en     = 1'b1;
                upd_poison = 1'b1;
            end
            OUT_IDLE, OUT_FAULT, OUT_RESUME, OUT_TRAP: ;
            default: ;
        endcase
    end

    spr_event_regs #(
        .IDX_W (IDX_W)
    ) u_events (
        .clk           (clk),
        .rst_n         (rst_n),
        .outcome       (outcome),
        .blame_b       (blame_b),
        .src_a         (wr_src_a),
        .src_b         (wr_src_b),
        .fault_valid   (fault_valid),
        .fault_src_idx (fault_src_idx),
        .resume_req    (resume_req),
        .trap_req      (trap_req)
    );

endmodule

// File: rtl/spr_checker.sv
module spr_checker #(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_valid,
    input logic              wr_spec,
    input logic              wr_exc_term,
    input logic              wr_exc_resum,
    input logic [IDX_W-1:0]  rd_a_idx,
    input logic [DATA_W-1:0] rd_a_data,
    input logic              fault_valid,
    input logic              resume_req,
    input logic              trap_req
);

    AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({fault_valid, resume_req, trap_req}) <= 1); // R11

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_valid |=> !fault_valid && !resume_req && !trap_req); // R10

    AST_SPEC_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && wr_spec |=> !fault_valid && !trap_req); // R5

    AST_FAULT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        fault_valid |-> $past(wr_valid && !wr_spec)); // R6

    AST_RESUME_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        resume_req |-> $past(wr_valid && wr_exc_resum)); // R7

    AST_TRAP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> $past(wr_valid && !wr_spec && wr_exc_term)); // R8

    AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!wr_valid) && $stable(rd_a_idx) |-> $stable(rd_a_data)); // R2

    always_comb begin
        if (!rst_n) begin
            AST_RESET_QUIET: assert (!fault_valid && !resume_req && !trap_req); // R1
        end
    end

endmodule

bind spec_poison_regfile spr_checker #(
    .DATA_W (DATA_W),
    .IDX_W  (IDX_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_valid     (wr_valid),
    .wr_spec      (wr_spec),
    .wr_exc_term  (wr_exc_term),
    .wr_exc_resum (wr_exc_resum),
    .rd_a_idx     (rd_a_idx),
    .rd_a_data    (rd_a_data),
    .fault_valid  (fault_valid),
    .resume_req   (resume_req),
    .trap_req     (trap_req)
);

// File: tb/spec_poison_regfile_tb.sv
module spec_poison_regfile_tb;

    localparam int NR = 16;
    localparam int DW = 32;
    localparam int IW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [IW-1:0] rd_a_idx = '0, rd_b_idx = '0;
    logic [DW-1:0] rd_a_data, rd_b_data;
    logic          rd_a_poison, rd_b_poison;
    logic          wr_valid = 1'b0, wr_spec = 1'b0;
    logic [IW-1:0] wr_dest = '0, wr_src_a = '0, wr_src_b = '0;
    logic [DW-1:0] wr_data = '0;
    logic          wr_use_a = 1'b0, wr_use_b = 1'b0;
    logic          wr_exc_term = 1'b0, wr_exc_resum = 1'b0;
    logic          fault_valid, resume_req, trap_req;
    logic [IW-1:0] fault_src_idx;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [DW-1:0] m_data [NR];
    logic          m_pois [NR];

    always #5 clk = ~clk;

    spec_poison_regfile #(.NUM_REGS(NR), .DATA_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data), .rd_a_poison(rd_a_poison),
        .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data), .rd_b_poison(rd_b_poison),
        .wr_valid(wr_valid), .wr_dest(wr_dest), .wr_data(wr_data), .wr_spec(wr_spec),
        .wr_use_a(wr_use_a), .wr_src_a(wr_src_a), .wr_use_b(wr_use_b), .wr_src_b(wr_src_b),
        .wr_exc_term(wr_exc_term), .wr_exc_resum(wr_exc_resum),
        .fault_valid(fault_valid), .fault_src_idx(fault_src_idx),
        .resume_req(resume_req), .trap_req(trap_req)
    );

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Called just after a falling edge; checks both read ports against the model.
    task automatic check_reads(string req, int a, int b);
        rd_a_idx = IW'(a);
        rd_b_idx = IW'(b);
        #1;
        chk(req, "port A data",   64'(rd_a_data),   64'(m_data[a]));
        chk(req, "port A poison", 64'(rd_a_poison), 64'(m_pois[a]));
        chk(req, "port B data",   64'(rd_b_data),   64'(m_data[b]));
        chk(req, "port B poison", 64'(rd_b_poison), 64'(m_pois[b]));
    endtask

    // Expected outcome code: 0 idle, 1 clean, 2 defer, 3 fault, 4 resume, 5 trap.
    function automatic int expect_kind(bit vld, bit spec, bit ua, int sa, bit ub, int sb,
                                       bit term, bit res);
        bit pa = ua && m_pois[sa];
        bit pb = ub && m_pois[sb];
        if (!vld) return 0;
        if (pa || pb) return spec ? 2 : 3;
        if (res) return 4;
        if (term) return spec ? 2 : 5;
        return 1;
    endfunction

    task automatic do_op(string req, bit vld, int dst, logic [DW-1:0] d, bit spec,
                         bit ua, int sa, bit ub, int sb, bit term, bit res);
        int kind;
        int fidx;
        kind = expect_kind(vld, spec, ua, sa, ub, sb, term, res);
        fidx = (ua && m_pois[sa]) ? sa : sb;
        wr_valid = vld; wr_dest = IW'(dst); wr_data = d; wr_spec = spec;
        wr_use_a = ua; wr_src_a = IW'(sa); wr_use_b = ub; wr_src_b = IW'(sb);
        wr_exc_term = term; wr_exc_resum = res;
        @(posedge clk);
        @(negedge clk);
        wr_valid = 1'b0;
        chk(req, "events {fault,resume,trap}",
            64'({fault_valid, resume_req, trap_req}),
            64'({kind == 3, kind == 4, kind == 5}));
        chk("R11", "event count", 64'($countones({fault_valid, resume_req, trap_req})),
            64'(kind >= 3 ? 1 : 0));
        if (kind == 3) chk(req, "fault index", 64'(fault_src_idx), 64'(fidx));
        if (kind == 1) begin
            m_data[dst] = d;
            m_pois[dst] = 1'b0;
        end else if (kind == 2) begin
            m_pois[dst] = 1'b1;
        end
        check_reads(req, dst, int'($urandom_range(NR - 1)));
    endtask

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'h5EED_0042);
        for (int i = 0; i < NR; i++) begin
            m_data[i] = '0;
            m_pois[i] = 1'b0;
        end
        repeat (3) @(negedge clk);
        // R1: state during and after reset.
        #1;
        chk("R1", "events in reset", 64'({fault_valid, resume_req, trap_req}), 64'(0));
        rst_n = 1'b1;
        for (int i = 0; i < NR; i += 2) check_reads("R1", i, i + 1);

        @(negedge clk);
        // R3: clean writes, non-speculative then speculative.
        do_op("R3", 1, 3, 32'hAAAA_0003, 0, 0, 0, 0, 0, 0, 0);
        do_op("R3", 1, 7, 32'h1234_5677, 1, 1, 3, 1, 4, 0, 0);
        // R2: two ports on different entries.
        check_reads("R2", 3, 7);
        // R4: speculative terminating exception poisons, keeps data.
        do_op("R4", 1, 3, 32'hDEAD_BEEF, 1, 0, 0, 0, 0, 1, 0);
        // R5: speculative consumer of poisoned 3 poisons 7, keeps data.
        do_op("R5", 1, 7, 32'h0BAD_0BAD, 1, 1, 3, 0, 0, 0, 1);
        // R6: non-speculative consumer of poisoned A.
        do_op("R6", 1, 9, 32'h0000_0009, 0, 1, 3, 1, 1, 0, 0);
        // R6: only B poisoned.
        do_op("R6", 1, 9, 32'h0000_0009, 0, 1, 1, 1, 7, 0, 0);
        // R6: both poisoned, A takes the blame.
        do_op("R6", 1, 9, 32'h0000_0009, 0, 1, 7, 1, 3, 1, 1);
        // R9: poisoned source not consumed; clean write.
        do_op("R9", 1, 9, 32'h0000_0099, 0, 0, 3, 0, 7, 0, 0);
        // R7: resumable, non-speculative and speculative.
        do_op("R7", 1, 9, 32'h1111_1111, 0, 1, 9, 0, 0, 1, 1);
        do_op("R7", 1, 9, 32'h2222_2222, 1, 0, 0, 0, 0, 0, 1);
        // R8: non-speculative terminating exception.
        do_op("R8", 1, 9, 32'h3333_3333, 0, 1, 9, 0, 3, 1, 0);
        // R3: clean non-speculative write clears poison on 3.
        do_op("R3", 1, 3, 32'h0000_3333, 0, 0, 3, 0, 7, 0, 0);
        // R10: idle cycle with busy-looking fields.
        do_op("R10", 0, 3, 32'hFFFF_FFFF, 1, 1, 7, 1, 7, 1, 1);

        // Random phase.
        for (int n = 0; n < 600; n++) begin
            bit vld  = ($urandom_range(9) != 0);
            bit spec = $urandom_range(1) == 1;
            bit ua   = $urandom_range(3) != 0;
            bit ub   = $urandom_range(1) == 1;
            bit term = $urandom_range(3) == 0;
            bit res  = $urandom_range(7) == 0;
            int dst  = int'($urandom_range(NR - 1));
            int sa   = int'($urandom_range(NR - 1));
            int sb   = int'($urandom_range(NR - 1));
            int k    = expect_kind(vld, spec, ua, sa, ub, sb, term, res);
            string tag;
            case (k)
                0: tag = "R10";
                1: tag = "R3";
                2: tag = (ua && m_pois[sa]) || (ub && m_pois[sb]) ? "R5" : "R4";
                3: tag = "R6";
                4: tag = "R7";
                default: tag = "R8";
            endcase
            do_op(tag, vld, dst, DW'($urandom), spec, ua, sa, ub, sb, term, res);
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule